// File: doc/BRIEF.md
# Vector Element-Wise Add/Subtract Sequencer

This block carries out one composite vector instruction, C[i] = A[i] op B[i] for i = 0 to n-1, without any per-element instruction fetch. A single start pulse delivers three base addresses, an element count and an operation code. The block then steps an element index in hardware. For each element it reads A and B from a single-port synchronous memory, combines them, and writes C. It signals completion after the last write.

The memory port is shared by reads and writes. Read data appears in the cycle after a read request. Every access targets base + index, taken modulo 2^AW. Each element takes four cycles: request A, request B, capture A, write C. An operation code outside the supported set, or a length of zero, finishes at once without touching memory. All outputs come straight from registers.

Top module: `vec_op_seq`

## Requirements
- R1: While rst is high, and in the first cycle after it, busy, done, err, mem_rd and mem_wr are all low.
- R2: A start with a legal code and a nonzero length is accepted on the clock edge where start is high and the block is idle. busy is high in the next cycle, and that cycle carries a read request at src_a_base.
- R3: Element i uses three accesses in strict order: a read at src_a_base+i, a read at src_b_base+i, then a write at dst_base+i. Elements are processed for i = 0 to n-1, and each element takes 4 cycles.
- R4: op_code 0 writes A+B and op_code 1 writes A-B. Both are taken modulo 2^DW.
- R5: With vec_len = 0 and a legal code, done is high for one cycle right after the accepting edge, err stays low, and no memory access occurs.
- R6: op_code 2 or 3 raises done and err together for one cycle right after the accepting edge, with no memory access, whatever the length.
- R7: start is ignored while busy. The running instruction completes unchanged, and no other addresses are accessed.
- R8: done rises 4·n cycles after the first busy cycle, one cycle after the last write request. It lasts one cycle, and busy is low from that cycle on.
- R9: All addresses wrap modulo 2^AW, so base 254 with index 2 addresses 0.
- R10: mem_rd and mem_wr are never high together, and neither is high while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction strobe; sampled only while idle |
| op_code | input | 2 | 0 = add, 1 = subtract, others illegal |
| src_a_base | input | AW | Base address of vector A |
| src_b_base | input | AW | Base address of vector B |
| dst_base | input | AW | Base address of result vector C |
| vec_len | input | LW | Number of elements |
| mem_rdata | input | DW | Read data, valid the cycle after a read request |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | DW | Write data |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal operation code, pulsed with done |

## Verification
A corrupted index or base register shows up within one element, as a wrong address in the access trace. A wrong length register shows up at the end of the run, as a wrong cycle count to done. A state machine that skips or repeats a step breaks the read-read-write order or the 4-cycle spacing within the first element. The captured A operand and the operation select are visible only through written memory, so each test compares every destination word against values computed in the bench. It also checks that addresses outside the destination range keep their initial contents.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

  localparam int OPW = 2;

  localparam logic [OPW-1:0] OPC_ADD = 2'd0;
  localparam logic [OPW-1:0] OPC_SUB = 2'd1;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQB,
    S_GETA,
    S_WRITE,
    S_STEP
  } seq_state_t;

  function automatic logic op_legal(input logic [OPW-1:0] op);
    return (op == OPC_ADD) || (op == OPC_SUB);
  endfunction

endpackage

// File: rtl/vseq_agen.sv
module vseq_agen #(
  parameter int AW = 8,
  parameter int LW = 8
) (
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] idx,
  output logic [AW-1:0] addr
);

  generate
    if (LW >= AW) begin : g_trunc
      assign addr = base + idx[AW-1:0];
    end else begin : g_ext
      localparam int PAD = AW - LW;
      assign addr = base + {{PAD{1'b0}}, idx};
    end
  endgenerate

endmodule

// File: rtl/vseq_alu.sv
module vseq_alu
  import vseq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  lhs,
  input  logic [DW-1:0]  rhs,
  output logic [DW-1:0]  res
);

  always_comb begin
    case (op)
      OPC_ADD: res = lhs + rhs;
      OPC_SUB: res = lhs - rhs;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
  import vseq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int LW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [OPW-1:0] op_in,
  input  logic [AW-1:0]  base_a_in,
  input  logic [AW-1:0]  base_b_in,
  input  logic [AW-1:0]  base_c_in,
  input  logic [LW-1:0]  len_in,
  input  logic [AW-1:0]  addr_a_nx,
  input  logic [AW-1:0]  addr_b,
  input  logic [AW-1:0]  addr_c,
  input  logic [DW-1:0]  alu_res,
  input  logic [DW-1:0]  mem_rdata,
  output logic [AW-1:0]  base_a_q,
  output logic [AW-1:0]  base_b_q,
  output logic [AW-1:0]  base_c_q,
  output logic [LW-1:0]  idx_q,
  output logic [LW-1:0]  idx_nx,
  output logic [OPW-1:0] op_q,
  output logic [DW-1:0]  a_hold,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic [DW-1:0]  mem_wdata,
  output logic           busy,
  output logic           done,
  output logic           err
);

  seq_state_t    state;
  logic [LW-1:0] len_q;
  logic          last_elem;

  assign idx_nx    = idx_q + LW'(1);
  assign last_elem = (idx_q == len_q - LW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      base_a_q  <= '0;
      base_b_q  <= '0;
      base_c_q  <= '0;
      len_q     <= '0;
      op_q      <= '0;
      idx_q     <= '0;
      a_hold    <= '0;
      mem_addr  <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_wdata <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        S_IDLE: begin
          mem_rd <= 1'b0;
          mem_wr <= 1'b0;
          if (start) begin
            base_a_q <= base_a_in;
            base_b_q <= base_b_in;
            base_c_q <= base_c_in;
            len_q    <= len_in;
            op_q     <= op_in;
            idx_q    <= '0;
            if (!op_legal(op_in)) begin
              done <= 1'b1;
              err  <= 1'b1;
            end else if (len_in == '0) begin
              done <= 1'b1;
            end else begin
              busy     <= 1'b1;
              mem_rd   <= 1'b1;
              mem_addr <= base_a_in;
              state    <= S_REQB;
            end
          end
        end
        S_REQB: begin
          mem_rd   <= 1'b1;
          mem_addr <= addr_b;
          state    <= S_GETA;
        end
        S_GETA: begin
          mem_rd <= 1'b0;
          a_hold <= mem_rdata;
          state  <= S_WRITE;
        end
        S_WRITE: begin
          mem_wr    <= 1'b1;
          mem_addr  <= addr_c;
          mem_wdata <= alu_res;
          state     <= S_STEP;
        end
        S_STEP: begin
          mem_wr <= 1'b0;
          if (last_elem) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            idx_q    <= idx_nx;
            mem_rd   <= 1'b1;
            mem_addr <= addr_a_nx;
            state    <= S_REQB;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10
  rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_rd && !mem_wr));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R6
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  // R7
  hold_instr_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(len_q) && $stable(base_c_q) && $stable(op_q)));

  // R3
  write_after_reads_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (!$past(mem_rd) && $past(mem_rd, 2)));

endmodule

// File: rtl/vec_op_seq.sv
module vec_op_seq
  import vseq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int LW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [OPW-1:0] op_code,
  input  logic [AW-1:0]  src_a_base,
  input  logic [AW-1:0]  src_b_base,
  input  logic [AW-1:0]  dst_base,
  input  logic [LW-1:0]  vec_len,
  input  logic [DW-1:0]  mem_rdata,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic [DW-1:0]  mem_wdata,
  output logic           busy,
  output logic           done,
  output logic           err
);

  logic [AW-1:0]  base_a_q, base_b_q, base_c_q;
  logic [AW-1:0]  addr_a_nx, addr_b, addr_c;
  logic [LW-1:0]  idx_q, idx_nx;
  logic [OPW-1:0] op_q;
  logic [DW-1:0]  a_hold, alu_res;

  vseq_agen #(.AW(AW), .LW(LW)) u_agen_a (
    .base(base_a_q), .idx(idx_nx), .addr(addr_a_nx)
  );

  vseq_agen #(.AW(AW), .LW(LW)) u_agen_b (
    .base(base_b_q), .idx(idx_q), .addr(addr_b)
  );

  vseq_agen #(.AW(AW), .LW(LW)) u_agen_c (
    .base(base_c_q), .idx(idx_q), .addr(addr_c)
  );

  vseq_alu #(.DW(DW)) u_alu (
    .op(op_q), .lhs(a_hold), .rhs(mem_rdata), .res(alu_res)
  );

  vseq_ctrl #(.AW(AW), .DW(DW), .LW(LW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .op_in(op_code),
    .base_a_in(src_a_base), .base_b_in(src_b_base), .base_c_in(dst_base),
    .len_in(vec_len), .addr_a_nx(addr_a_nx), .addr_b(addr_b),
    .addr_c(addr_c), .alu_res(alu_res), .mem_rdata(mem_rdata),
    .base_a_q(base_a_q), .base_b_q(base_b_q), .base_c_q(base_c_q),
    .idx_q(idx_q), .idx_nx(idx_nx), .op_q(op_q), .a_hold(a_hold),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .busy(busy), .done(done), .err(err)
  );

endmodule

// File: tb/test_vec_op_seq.sv
module test_vec_op_seq;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int LW = 8;
  localparam int MEMN = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    op_code = '0;
  logic [AW-1:0] src_a_base = '0, src_b_base = '0, dst_base = '0;
  logic [LW-1:0] vec_len = '0;
  logic [DW-1:0] mem_rdata = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr, busy, done, err;
  logic [DW-1:0] mem_wdata;

  logic [DW-1:0] mem [0:MEMN-1];
  int            tr_n = 0;
  logic          tr_kind [0:63];
  int            tr_addr [0:63];
  int            viol = 0;
  int            total = 0;
  int            bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_op_seq #(.AW(AW), .DW(DW), .LW(LW)) i_vec_op_seq (
    .clk(clk), .rst(rst), .start(start), .op_code(op_code),
    .src_a_base(src_a_base), .src_b_base(src_b_base), .dst_base(dst_base),
    .vec_len(vec_len), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .busy(busy), .done(done), .err(err)
  );

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk) begin
    if (!rst) begin
      if ((mem_rd && mem_wr) || ((mem_rd || mem_wr) && !busy)) viol++;
      if ((mem_rd || mem_wr) && tr_n < 64) begin
        tr_kind[tr_n] = mem_wr;
        tr_addr[tr_n] = int'(mem_addr);
        tr_n++;
      end
    end
  end

  function automatic logic [DW-1:0] pat(input int k);
    return DW'((k % MEMN) * 731 + 97);
  endfunction

  function automatic logic [DW-1:0] expv(input int op, input int a, input int b, input int i);
    logic [DW-1:0] x, y;
    x = pat((a + i) % MEMN);
    y = pat((b + i) % MEMN);
    return (op == 1) ? DW'(x - y) : DW'(x + y);
  endfunction

  task automatic chk(input logic ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int k = 0; k < MEMN; k++) mem[k] = pat(k);
  endtask

  task automatic run_vec(input int op, input int a, input int b, input int c, input int len,
                         output int cyc, output logic err_seen, output logic busy1);
    @(negedge clk);
    op_code = 2'(op); src_a_base = AW'(a); src_b_base = AW'(b);
    dst_base = AW'(c); vec_len = LW'(len); tr_n = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy1 = busy;
    cyc = 1;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    err_seen = err;
  endtask

  task automatic chk_vector(input string req, input int op, input int a, input int b, input int c, input int len);
    int mism = 0;
    int order = 0;
    for (int i = 0; i < len; i++) begin
      if (mem[(c + i) % MEMN] !== expv(op, a, b, i)) mism++;
      if (3*i + 2 < 64) begin
        if (tr_kind[3*i] !== 1'b0 || tr_addr[3*i] != (a + i) % MEMN) order++;
        if (tr_kind[3*i+1] !== 1'b0 || tr_addr[3*i+1] != (b + i) % MEMN) order++;
        if (tr_kind[3*i+2] !== 1'b1 || tr_addr[3*i+2] != (c + i) % MEMN) order++;
      end
    end
    chk(mism == 0, req, "result words mismatching", mism, 0);
    chk(order == 0, "R3", "access order/address errors", order, 0);
    chk(tr_n == 3*len, "R3", "access count", tr_n, 3*len);
    chk(mem[(c + len) % MEMN] === pat((c + len) % MEMN), req, "word past end untouched",
        int'(mem[(c + len) % MEMN]), int'(pat((c + len) % MEMN)));
  endtask

  task automatic t_reset();
    chk(!busy && !done && !err && !mem_rd && !mem_wr, "R1", "outputs in reset",
        int'({busy, done, err, mem_rd, mem_wr}), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !err && !mem_rd && !mem_wr, "R1", "outputs after reset",
        int'({busy, done, err, mem_rd, mem_wr}), 0);
  endtask

  task automatic t_add();
    int cyc; logic e, b1;
    init_mem();
    run_vec(0, 16, 48, 96, 3, cyc, e, b1);
    chk(b1 == 1'b1, "R2", "busy after accept", int'(b1), 1);
    chk(tr_addr[0] == 16 && tr_kind[0] == 1'b0, "R2", "first access is read of A", tr_addr[0], 16);
    chk(cyc == 13, "R8", "cycles to done (add, n=3)", cyc, 13);
    chk(e == 1'b0, "R4", "err on add", int'(e), 0);
    chk_vector("R4", 0, 16, 48, 96, 3);
    @(negedge clk);
    chk(!done && !busy, "R8", "done lasts one cycle", int'({done, busy}), 0);
  endtask

  task automatic t_sub();
    int cyc; logic e, b1;
    init_mem();
    run_vec(1, 20, 52, 128, 5, cyc, e, b1);
    chk(cyc == 21, "R8", "cycles to done (sub, n=5)", cyc, 21);
    chk_vector("R4", 1, 20, 52, 128, 5);
  endtask

  task automatic t_len0();
    int cyc; logic e, b1;
    init_mem();
    run_vec(0, 10, 30, 160, 0, cyc, e, b1);
    chk(cyc == 1, "R5", "zero length done delay", cyc, 1);
    chk(e == 1'b0 && b1 == 1'b0, "R5", "err/busy on zero length", int'({e, b1}), 0);
    chk(tr_n == 0, "R5", "accesses on zero length", tr_n, 0);
    @(negedge clk);
    chk(!done, "R5", "done single cycle", int'(done), 0);
  endtask

  task automatic t_badop();
    int cyc; logic e, b1;
    init_mem();
    for (int op = 2; op < 4; op++) begin
      run_vec(op, 10, 30, 170, 3, cyc, e, b1);
      chk(cyc == 1, "R6", "illegal code done delay", cyc, 1);
      chk(e == 1'b1, "R6", "err with done", int'(e), 1);
      chk(tr_n == 0 && mem[170] === pat(170), "R6", "accesses on illegal code", tr_n, 0);
      @(negedge clk);
      chk(!err && !done, "R6", "err single cycle", int'({err, done}), 0);
    end
  endtask

  task automatic t_busy_start();
    int cyc = 1;
    init_mem();
    @(negedge clk);
    op_code = 2'd0; src_a_base = 8'd0; src_b_base = 8'd32; dst_base = 8'd200;
    vec_len = 8'd2; tr_n = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) begin @(negedge clk); cyc++; end
    op_code = 2'd1; src_a_base = 8'd40; src_b_base = 8'd60; dst_base = 8'd220;
    vec_len = 8'd4; start = 1'b1;
    @(negedge clk); cyc++;
    start = 1'b0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    chk(cyc == 9, "R7", "cycles with start while busy", cyc, 9);
    chk(mem[220] === pat(220), "R7", "second destination untouched", int'(mem[220]), int'(pat(220)));
    chk_vector("R7", 0, 0, 32, 200, 2);
    @(negedge clk);
  endtask

  task automatic t_wrap();
    int cyc; logic e, b1;
    init_mem();
    run_vec(0, 253, 120, 140, 4, cyc, e, b1);
    chk_vector("R9", 0, 253, 120, 140, 4);
    init_mem();
    run_vec(1, 70, 100, 254, 4, cyc, e, b1);
    chk_vector("R9", 1, 70, 100, 254, 4);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    init_mem();
    repeat (3) @(negedge clk);
    t_reset();
    t_add();
    t_sub();
    t_len0();
    t_badop();
    t_busy_start();
    t_wrap();
    chk(viol == 0, "R10", "cycles with overlapping or idle accesses", viol, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule